// File: doc/BRIEF.md
# Zero-Overhead Loop Controller

This block keeps the state of two nested loops run by hardware, so that a loop body repeats without any branch instruction. Each loop has a start address, an end address and a remaining-iteration count. A decode stage sends setup commands that place the start or the end at a halfword-scaled distance from the setup instruction's own address, or that load the count from a register value or from an immediate. A combined short setup writes all three fields of one loop at once. In that case the start becomes the instruction right after the setup.

The block compares the fetch program counter against both loop ends every cycle. When the address matches a loop end and more than one iteration remains, it raises a redirect to that loop's start in the same cycle and decrements the count at the next clock edge. On the last iteration, fetch falls through and the count is cleared. Loop 0 is the inner loop. While loop 0 is matching, loop 1 is not evaluated. All fields of both loops can be read back through a selected readback port.

Top module: `hwloop_ctrl`

## Requirements
- R1: After synchronous reset, all start, end and count fields of both loops read back as zero, and no redirect is raised.
- R2: With cmd_valid high and cmd_op = 1, the start of loop cmd_idx becomes cmd_pc + (zero-extended cmd_ofs shifted left by one).
- R3: With cmd_valid high and cmd_op = 2, the end of loop cmd_idx becomes cmd_pc + (zero-extended cmd_ofs shifted left by one).
- R4: cmd_op = 3 loads the count of loop cmd_idx from cmd_rs. cmd_op = 4 loads it from zero-extended cmd_cimm.
- R5: cmd_op = 5 writes the following in one cycle: start = cmd_pc + 4, end = cmd_pc + (cmd_ofs << 1) and count = cmd_rs. cmd_op = 6 does the same, except that the count comes from cmd_cimm.
- R6: When fetch_pc equals the end of an evaluated loop and its count is greater than 1, redir_valid is high in that same cycle with redir_target equal to that loop's start, and the count is one lower after the next clock edge.
- R7: When fetch_pc equals a loop end and the count is 1, no redirect is raised and the count becomes 0. A count of 0 never redirects and stays 0.
- R8: While fetch_pc equals the end of loop 0 and loop 0's count is nonzero, loop 1 neither redirects nor changes its count.
- R9: Once loop 0's count is 0, loop 1 is evaluated at its own end as in R6 and R7.
- R10: A command that writes a loop's count in the same cycle as that loop decrements leaves the commanded value, not the decremented one.
- R11: With cmd_valid low, or with cmd_op 0 or 7, no loop field changes.
- R12: A command changes only the loop selected by cmd_idx (0 or 1). The other loop's fields are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Setup command present this cycle |
| cmd_op | input | 3 | Command code: 0 none, 1 start, 2 end, 3 count from register, 4 count from immediate, 5 short setup with register count, 6 short setup with immediate count, 7 none |
| cmd_idx | input | 1 | Selected loop |
| cmd_pc | input | ADDR_W | Address of the setup instruction |
| cmd_ofs | input | OFS_W | Unsigned halfword offset for start or end |
| cmd_cimm | input | CIMM_W | Unsigned immediate count |
| cmd_rs | input | CNT_W | Register-supplied count |
| fetch_pc | input | ADDR_W | Current fetch address |
| redir_valid | output | 1 | Redirect fetch this cycle |
| redir_target | output | ADDR_W | Redirect address |
| rd_sel | input | 1 | Loop selected for readback |
| rd_start | output | ADDR_W | Start of the selected loop |
| rd_end | output | ADDR_W | End of the selected loop |
| rd_count | output | CNT_W | Count of the selected loop |

## Verification
Two functions can land in the same cycle: a count write from a setup command and the end-of-loop decrement of the same loop. Two others can also coincide: loop 0 and loop 1 matching one shared end address. The bench provokes the first case by holding fetch_pc on loop 0's end while it issues an immediate count write to loop 0. It then checks that the redirect still appears and that the readback count equals the commanded value. For the shared end, both loops are placed on one address. The bench then checks that loop 0 redirects alone, that loop 1's count is untouched through loop 0's last pass, and that loop 1 redirects only after loop 0 reaches zero.

// File: rtl/hwl_pkg.sv
package hwl_pkg;

    localparam int NLOOPS = 2;

    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_SET_START = 3'd1,
        OP_SET_END   = 3'd2,
        OP_CNT_REG   = 3'd3,
        OP_CNT_IMM   = 3'd4,
        OP_SHORT_REG = 3'd5,
        OP_SHORT_IMM = 3'd6,
        OP_RSVD      = 3'd7
    } hwl_op_e;

    // Which fields of a loop a command writes
    typedef struct packed {
        logic start;
        logic stop;
        logic count;
    } hwl_we_t;

    // Per-loop match status for one cycle
    typedef struct packed {
        logic hit;   // fetch on end with nonzero count
        logic act;   // hit and allowed to act by priority
        logic jump;  // act with more than one iteration left
    } hwl_evt_t;

    function automatic hwl_we_t op_fields(hwl_op_e op);
        hwl_we_t f;
        f = '0;
        unique case (op)
            OP_SET_START: f.start = 1'b1;
            OP_SET_END:   f.stop  = 1'b1;
            OP_CNT_REG,
            OP_CNT_IMM:   f.count = 1'b1;
            OP_SHORT_REG,
            OP_SHORT_IMM: f = '{start: 1'b1, stop: 1'b1, count: 1'b1};
            default:      f = '0;
        endcase
        return f;
    endfunction

    function automatic logic count_from_imm(hwl_op_e op);
        return (op == OP_CNT_IMM) || (op == OP_SHORT_IMM);
    endfunction

endpackage

// File: rtl/hwl_setup_dec.sv
module hwl_setup_dec
    import hwl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32,
    parameter int OFS_W  = 12,
    parameter int CIMM_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic              cmd_idx,
    input  logic [ADDR_W-1:0] cmd_pc,
    input  logic [OFS_W-1:0]  cmd_ofs,
    input  logic [CIMM_W-1:0] cmd_cimm,
    input  logic [CNT_W-1:0]  cmd_rs,
    output hwl_we_t           we_o [NLOOPS],
    output logic [ADDR_W-1:0] start_val_o,
    output logic [ADDR_W-1:0] end_val_o,
    output logic [CNT_W-1:0]  cnt_val_o
);

    localparam int PAD_A = ADDR_W - OFS_W - 1;
    localparam int PAD_C = CNT_W - CIMM_W;
    localparam logic [ADDR_W-1:0] NEXT_INSN = ADDR_W'(4);

    hwl_op_e               op;
    hwl_we_t               fields;
    logic [ADDR_W-1:0]     ofs_addr;

    assign op       = hwl_op_e'(cmd_op);
    assign fields   = cmd_valid ? op_fields(op) : '0;
    assign ofs_addr = cmd_pc + {{PAD_A{1'b0}}, cmd_ofs, 1'b0};

    always_comb begin
        start_val_o = ofs_addr;
        if (op == OP_SHORT_REG || op == OP_SHORT_IMM) begin
            start_val_o = cmd_pc + NEXT_INSN;
        end
        end_val_o = ofs_addr;
        cnt_val_o = count_from_imm(op) ? {{PAD_C{1'b0}}, cmd_cimm} : cmd_rs;
    end

    generate
        for (genvar g = 0; g < NLOOPS; g++) begin : g_sel
            assign we_o[g] = (cmd_idx == g[0]) ? fields : '0;
        end
    endgenerate

    // R12: a command reaches at most one loop
    assert_one_loop_R12: assert property (@(posedge clk) disable iff (rst)
        !(we_o[0].count && we_o[1].count) && !(we_o[0].start && we_o[1].start));

endmodule

// File: rtl/hwl_loop_slot.sv
module hwl_loop_slot
    import hwl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  hwl_we_t           we_i,
    input  logic [ADDR_W-1:0] start_val,
    input  logic [ADDR_W-1:0] end_val,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              allow_i,
    output logic [ADDR_W-1:0] start_o,
    output logic [ADDR_W-1:0] end_o,
    output logic [CNT_W-1:0]  cnt_o,
    output hwl_evt_t          evt_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [ADDR_W-1:0] start_q, end_q;
    logic [CNT_W-1:0]  cnt_q;
    hwl_evt_t          evt;

    always_comb begin
        evt.hit  = (fetch_pc == end_q) && (cnt_q != '0);
        evt.act  = evt.hit && allow_i;
        evt.jump = evt.act && (cnt_q > ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            end_q   <= '0;
            cnt_q   <= '0;
        end else begin
            if (we_i.start) start_q <= start_val;
            if (we_i.stop)  end_q   <= end_val;
            if (we_i.count)   cnt_q <= cnt_val;
            else if (evt.act) cnt_q <= cnt_q - ONE;
        end
    end

    assign start_o = start_q;
    assign end_o   = end_q;
    assign cnt_o   = cnt_q;
    assign evt_o   = evt;

    // R6: a taken loop-back lowers the count by one
    assert_jump_dec_R6: assert property (@(posedge clk) disable iff (rst)
        (evt.jump && !we_i.count) |=> (cnt_q == $past(cnt_q) - ONE));

    // R7: the last pass clears the count
    assert_last_pass_R7: assert property (@(posedge clk) disable iff (rst)
        (evt.act && cnt_q == ONE && !we_i.count) |=> (cnt_q == '0));

    // R10: a commanded count wins over the decrement
    assert_cmd_wins_R10: assert property (@(posedge clk) disable iff (rst)
        we_i.count |=> (cnt_q == $past(cnt_val)));

    // R11: without a write or an action the count holds
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!we_i.count && !evt.act) |=> $stable(cnt_q));

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
    import hwl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32,
    parameter int OFS_W  = 12,
    parameter int CIMM_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic              cmd_idx,
    input  logic [ADDR_W-1:0] cmd_pc,
    input  logic [OFS_W-1:0]  cmd_ofs,
    input  logic [CIMM_W-1:0] cmd_cimm,
    input  logic [CNT_W-1:0]  cmd_rs,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              redir_valid,
    output logic [ADDR_W-1:0] redir_target,
    input  logic              rd_sel,
    output logic [ADDR_W-1:0] rd_start,
    output logic [ADDR_W-1:0] rd_end,
    output logic [CNT_W-1:0]  rd_count
);

    hwl_we_t           we      [NLOOPS];
    logic [ADDR_W-1:0] start_w [NLOOPS];
    logic [ADDR_W-1:0] end_w   [NLOOPS];
    logic [CNT_W-1:0]  cnt_w   [NLOOPS];
    hwl_evt_t          evt     [NLOOPS];
    logic [NLOOPS-1:0] allow;
    logic [ADDR_W-1:0] start_val, end_val;
    logic [CNT_W-1:0]  cnt_val;

    hwl_setup_dec #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .OFS_W(OFS_W), .CIMM_W(CIMM_W)
    ) u_dec (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
        .cmd_pc(cmd_pc), .cmd_ofs(cmd_ofs), .cmd_cimm(cmd_cimm), .cmd_rs(cmd_rs),
        .we_o(we), .start_val_o(start_val), .end_val_o(end_val), .cnt_val_o(cnt_val)
    );

    // Inner loop first: a loop may act only if no lower-index loop hits
    always_comb begin
        logic blocked;
        blocked = 1'b0;
        for (int i = 0; i < NLOOPS; i++) begin
            allow[i] = !blocked;
            blocked  = blocked | evt[i].hit;
        end
    end

    generate
        for (genvar g = 0; g < NLOOPS; g++) begin : g_loop
            hwl_loop_slot #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_slot (
                .clk(clk), .rst(rst), .we_i(we[g]),
                .start_val(start_val), .end_val(end_val), .cnt_val(cnt_val),
                .fetch_pc(fetch_pc), .allow_i(allow[g]),
                .start_o(start_w[g]), .end_o(end_w[g]), .cnt_o(cnt_w[g]),
                .evt_o(evt[g])
            );
        end
    endgenerate

    always_comb begin
        redir_valid  = 1'b0;
        redir_target = '0;
        for (int i = NLOOPS - 1; i >= 0; i--) begin
            if (evt[i].jump) begin
                redir_valid  = 1'b1;
                redir_target = start_w[i];
            end
        end
    end

    assign rd_start = start_w[rd_sel];
    assign rd_end   = end_w[rd_sel];
    assign rd_count = cnt_w[rd_sel];

    // R6: a redirect only happens on a loop end
    assert_redir_on_end_R6: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> (fetch_pc == end_w[0] || fetch_pc == end_w[1]));

    // R8: outer loop count frozen while the inner loop hits
    assert_inner_first_R8: assert property (@(posedge clk) disable iff (rst)
        (evt[0].hit && !we[1].count) |=> $stable(cnt_w[1]));

    // R8: at most one loop redirects
    assert_single_jump_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt[1].jump, evt[0].jump}));

    // R11: idle command slot leaves the start fields alone
    assert_idle_start_R11: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> ($stable(start_w[0]) && $stable(start_w[1])));

endmodule

// File: tb/sim_hwloop_ctrl.sv
module sim_hwloop_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic        cmd_idx;
    logic [31:0] cmd_pc;
    logic [11:0] cmd_ofs;
    logic [11:0] cmd_cimm;
    logic [31:0] cmd_rs;
    logic [31:0] fetch_pc;
    logic        redir_valid;
    logic [31:0] redir_target;
    logic        rd_sel;
    logic [31:0] rd_start, rd_end, rd_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [31:0] IDLE_PC = 32'hDEAD_0000;
    localparam int NV = 6;
    localparam logic [2:0]  T_OP  [NV] = '{3'd1, 3'd2, 3'd4, 3'd5, 3'd6, 3'd3};
    localparam logic        T_IDX [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic [31:0] T_PC  [NV] = '{32'h100, 32'h104, 32'h0, 32'h200, 32'h300, 32'h0};
    localparam logic [11:0] T_OFS [NV] = '{12'h010, 12'h020, 12'h0, 12'h040, 12'hFFF, 12'h0};
    localparam logic [11:0] T_CI  [NV] = '{12'h0, 12'h0, 12'h005, 12'h0, 12'hABC, 12'h0};
    localparam logic [31:0] T_RS  [NV] = '{32'h0, 32'h0, 32'h0, 32'h12345, 32'h0, 32'hFFFF_FFFF};
    localparam logic [31:0] E_ST  [NV] = '{32'h120, 32'h120, 32'h120, 32'h204, 32'h304, 32'h120};
    localparam logic [31:0] E_EN  [NV] = '{32'h0, 32'h144, 32'h144, 32'h280, 32'h22FE, 32'h144};
    localparam logic [31:0] E_CN  [NV] = '{32'h0, 32'h0, 32'h5, 32'h12345, 32'hABC, 32'hFFFF_FFFF};

    hwloop_ctrl u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
        .cmd_pc(cmd_pc), .cmd_ofs(cmd_ofs), .cmd_cimm(cmd_cimm), .cmd_rs(cmd_rs),
        .fetch_pc(fetch_pc), .redir_valid(redir_valid), .redir_target(redir_target),
        .rd_sel(rd_sel), .rd_start(rd_start), .rd_end(rd_end), .rd_count(rd_count)
    );

    always #5 clk = ~clk;

    function automatic string req_of(logic [2:0] op);
        case (op)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3, 3'd4: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_cmd(logic [2:0] op, logic idx, logic [31:0] pc,
                          logic [11:0] ofs, logic [11:0] ci, logic [31:0] rs);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx;
        cmd_pc = pc; cmd_ofs = ofs; cmd_cimm = ci; cmd_rs = rs;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic chk_loop(string req, logic idx, logic [31:0] s, logic [31:0] e, logic [31:0] c);
        rd_sel = idx;
        #1;
        chk(req, rd_start, s);
        chk(req, rd_end, e);
        chk(req, rd_count, c);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_idx = 1'b0;
        cmd_pc = '0; cmd_ofs = '0; cmd_cimm = '0; cmd_rs = '0;
        fetch_pc = IDLE_PC; rd_sel = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk_loop("R1", 1'b0, 32'h0, 32'h0, 32'h0);
        chk_loop("R1", 1'b1, 32'h0, 32'h0, 32'h0);
        chk("R1", {31'b0, redir_valid}, 32'h0);

        // R11: command without valid, and reserved code 7
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd1; cmd_pc = 32'h500; cmd_ofs = 12'h1; cmd_rs = 32'h77;
        @(negedge clk);
        chk_loop("R11", 1'b0, 32'h0, 32'h0, 32'h0);
        do_cmd(3'd7, 1'b0, 32'h500, 12'h1, 12'h3, 32'h77);
        chk_loop("R11", 1'b0, 32'h0, 32'h0, 32'h0);

        // Table of setup commands
        for (int i = 0; i < NV; i++) begin
            do_cmd(T_OP[i], T_IDX[i], T_PC[i], T_OFS[i], T_CI[i], T_RS[i]);
            chk_loop(req_of(T_OP[i]), T_IDX[i], E_ST[i], E_EN[i], E_CN[i]);
        end
        // R12: loop 1 untouched by the last loop 0 count write
        chk_loop("R12", 1'b1, 32'h304, 32'h22FE, 32'hABC);

        // Loop run on loop 0: start 0x1000, end 0x1010, count 3
        do_cmd(3'd1, 1'b0, 32'h1000, 12'h0, 12'h0, 32'h0);
        do_cmd(3'd2, 1'b0, 32'h1000, 12'h8, 12'h0, 32'h0);
        do_cmd(3'd4, 1'b0, 32'h0, 12'h0, 12'h3, 32'h0);
        rd_sel = 1'b0;
        @(negedge clk); fetch_pc = 32'h1010; #1;
        chk("R6", {31'b0, redir_valid}, 32'h1);
        chk("R6", redir_target, 32'h1000);
        @(negedge clk); #1;
        chk("R6", rd_count, 32'h2);
        chk("R6", {31'b0, redir_valid}, 32'h1);
        @(negedge clk); #1;
        chk("R7", rd_count, 32'h1);
        chk("R7", {31'b0, redir_valid}, 32'h0);
        @(negedge clk); #1;
        chk("R7", rd_count, 32'h0);
        @(negedge clk); #1;
        chk("R7", rd_count, 32'h0);
        chk("R7", {31'b0, redir_valid}, 32'h0);
        fetch_pc = IDLE_PC;

        // Shared end: loop 1 start 0xFF4, end 0x1010, count 2; loop 0 count 2
        do_cmd(3'd5, 1'b1, 32'h0FF0, 12'h010, 12'h0, 32'h2);
        chk_loop("R5", 1'b1, 32'h0FF4, 32'h1010, 32'h2);
        do_cmd(3'd4, 1'b0, 32'h0, 12'h0, 12'h2, 32'h0);
        @(negedge clk); fetch_pc = 32'h1010; #1;
        chk("R8", {31'b0, redir_valid}, 32'h1);
        chk("R8", redir_target, 32'h1000);
        @(negedge clk); rd_sel = 1'b1; #1;
        chk("R8", {31'b0, redir_valid}, 32'h0);
        chk("R8", rd_count, 32'h2);
        @(negedge clk); #1;
        chk("R8", rd_count, 32'h2);
        chk("R9", {31'b0, redir_valid}, 32'h1);
        chk("R9", redir_target, 32'h0FF4);
        @(negedge clk); #1;
        chk("R9", rd_count, 32'h1);
        fetch_pc = IDLE_PC;

        // R10: count write collides with a decrement of loop 0
        do_cmd(3'd4, 1'b0, 32'h0, 12'h0, 12'h5, 32'h0);
        @(negedge clk);
        fetch_pc = 32'h1010;
        cmd_valid = 1'b1; cmd_op = 3'd4; cmd_idx = 1'b0; cmd_cimm = 12'h9;
        #1;
        chk("R10", {31'b0, redir_valid}, 32'h1);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0; fetch_pc = IDLE_PC; rd_sel = 1'b0;
        #1;
        chk("R10", rd_count, 32'h9);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule